// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two predictors side by side and letting a per-address chooser pick between them. The global predictor indexes a table of 2-bit saturating counters with a 12-bit shift register of the most recent branch outcomes. The local predictor is two-level. A 1024-entry table keeps a 10-bit outcome history for each branch, and that history selects one of 1024 3-bit saturating counters.

A fetch stage drives a branch PC on the prediction port. In the same cycle, with no register in the path, it receives the final direction, both component directions and the chooser's selection. When the branch resolves, the pipeline presents the PC, the real outcome and the two component directions it captured at prediction time on the update port. On that clock edge the block trains the counters that the pre-update histories point at, trains the chooser when the components disagreed, and then shifts the outcome into both the branch's local history and the global history.

Top module: `tournament_bp`

## Requirements
- R1: After reset all histories are zero, global and chooser counters hold 1, local counters hold 3, so every PC predicts not taken with the local predictor selected.
- R2: `pred_glob_o` is 1 exactly when the global counter addressed by the current global history holds 2 or more.
- R3: On a valid update, the global counter addressed by the pre-update global history moves up by one on taken and down by one on not taken, saturating at 0 and 3.
- R4: On a valid update, the global history shifts left by one and the outcome enters bit 0. Only the last 12 outcomes remain.
- R5: `pred_loc_o` is 1 exactly when the local counter addressed by the history entry at PC bits [11:2] holds 4 or more. The local counters are shared by all branches whose histories match.
- R6: On a valid update, the local counter addressed by the branch's pre-update local history saturates at 0 and 7 while moving toward the outcome. The history entry then shifts the outcome into bit 0.
- R7: The chooser counter at PC bits [13:2] selects the global prediction when it holds 2 or more and the local prediction otherwise. `pred_taken_o` equals the selected component.
- R8: The chooser counter changes only when the two captured component predictions differ. It moves one step toward the global side when the global one matched the outcome and toward the local side otherwise, saturating at 0 and 3.
- R9: While `upd_valid_i` is low, no history or counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_pc_i | input | 32 | PC of the branch being predicted |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_glob_o | output | 1 | Global component direction |
| pred_loc_o | output | 1 | Local component direction |
| pred_use_glob_o | output | 1 | 1 when the chooser selects the global component |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_glob_pred_i | input | 1 | Global direction captured at prediction time |
| upd_loc_pred_i | input | 1 | Local direction captured at prediction time |

## Verification
The bench targets the history index boundaries. A taken outcome followed by twelve not-taken ones must bring the global history back to zero and reach the counter trained first; a design with an off-by-one history width would address a different counter. It checks that one branch's training shows up in another branch's local prediction through the shared second-level table, which a design indexing that table by PC would miss. It drives the chooser into both saturation limits, sends agreeing updates and an update with the valid bit low, and checks the selection after each. Wrapping counters, training on agreement or acting on an invalid update each change a selection that the bench has worked out by hand.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int PC_W_DEF      = 32;
  localparam int PC_LSB_DEF    = 2;
  localparam int CHOOSE_IW_DEF = 12;
  localparam int GHIST_W_DEF   = 12;
  localparam int LHT_IW_DEF    = 10;
  localparam int LHIST_W_DEF   = 10;
  localparam int GCTR_W_DEF    = 2;
  localparam int LCTR_W_DEF    = 3;
  localparam int CCTR_W_DEF    = 2;
endpackage

// File: rtl/bp_ctr_table.sv
// Table of saturating counters: one combinational read port, one train port.
module bp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_hi_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] MAX_V  = '1;
  localparam logic [CTR_W-1:0] ZERO_V = '0;
  localparam logic [CTR_W-1:0] ONE_V  = CTR_W'(1);
  localparam logic [CTR_W-1:0] INIT_V = CTR_W'(INIT);

  logic [CTR_W-1:0] tbl_q [DEPTH];
  logic [CTR_W-1:0] cur, nxt;

  assign cur = tbl_q[wr_idx_i];

  always_comb begin
    nxt = cur;
    if (wr_up_i) begin
      if (cur != MAX_V) nxt = cur + ONE_V;
    end else begin
      if (cur != ZERO_V) nxt = cur - ONE_V;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= INIT_V;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= nxt;
    end
  end

  // upper half of the range predicts taken
  assign rd_hi_o = tbl_q[rd_idx_i][CTR_W-1];

  a_r3_r6_r8_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cur == MAX_V) |=> tbl_q[$past(wr_idx_i)] == MAX_V);
  a_r3_r6_r8_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cur == ZERO_V) |=> tbl_q[$past(wr_idx_i)] == ZERO_V);
  a_r9_ctr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> tbl_q[$past(wr_idx_i)] == $past(cur));
endmodule

// File: rtl/bp_hist_table.sv
// Per-branch outcome histories: prediction read, update read and shift.
module bp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_bit_i,
  output logic [HIST_W-1:0] upd_hist_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] tbl_q [DEPTH];

  assign rd_hist_o  = tbl_q[rd_idx_i];
  assign upd_hist_o = tbl_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (upd_en_i) begin
      tbl_q[upd_idx_i] <= {upd_hist_o[HIST_W-2:0], upd_bit_i};
    end
  end

  a_r6_hist_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> tbl_q[$past(upd_idx_i)][0] == $past(upd_bit_i));
  a_r9_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> tbl_q[$past(upd_idx_i)] == $past(upd_hist_o));
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] hist_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[W-2:0], bit_i};
  end

  assign hist_o = hist_q;

  a_r9_ghr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(hist_q));
  a_r4_ghr_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> hist_q[0] == $past(bit_i));
  a_r4_ghr_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> hist_q[W-1:1] == $past(hist_q[W-2:0]));
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import bp_pkg::*;
#(
  parameter int PC_W     = PC_W_DEF,
  parameter int PC_LSB   = PC_LSB_DEF,
  parameter int CHOOSE_IW = CHOOSE_IW_DEF,
  parameter int GHIST_W  = GHIST_W_DEF,
  parameter int LHT_IW   = LHT_IW_DEF,
  parameter int LHIST_W  = LHIST_W_DEF,
  parameter int GCTR_W   = GCTR_W_DEF,
  parameter int LCTR_W   = LCTR_W_DEF,
  parameter int CCTR_W   = CCTR_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_glob_o,
  output logic            pred_loc_o,
  output logic            pred_use_glob_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_glob_pred_i,
  input  logic            upd_loc_pred_i
);
  // weak not-taken reset values
  localparam int GCTR_INIT = (1 << (GCTR_W - 1)) - 1;
  localparam int LCTR_INIT = (1 << (LCTR_W - 1)) - 1;
  localparam int CCTR_INIT = (1 << (CCTR_W - 1)) - 1;

  logic [CHOOSE_IW-1:0] pred_cidx, upd_cidx;
  logic [LHT_IW-1:0]    pred_lidx, upd_lidx;
  logic [GHIST_W-1:0]   ghist;
  logic [LHIST_W-1:0]   pred_lhist, upd_lhist;
  logic                 ch_train, ch_up;
  logic                 unused_pc;

  assign pred_cidx = pred_pc_i[PC_LSB +: CHOOSE_IW];
  assign upd_cidx  = upd_pc_i[PC_LSB +: CHOOSE_IW];
  assign pred_lidx = pred_pc_i[PC_LSB +: LHT_IW];
  assign upd_lidx  = upd_pc_i[PC_LSB +: LHT_IW];
  assign unused_pc = ^{pred_pc_i, upd_pc_i};

  bp_ghist #(.W(GHIST_W)) u_ghist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (upd_valid_i),
    .bit_i      (upd_taken_i),
    .hist_o     (ghist)
  );

  // global counters: read and train at the pre-update history
  bp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .INIT(GCTR_INIT)) u_gctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (ghist),
    .rd_hi_o  (pred_glob_o),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (ghist),
    .wr_up_i  (upd_taken_i)
  );

  bp_hist_table #(.IDX_W(LHT_IW), .HIST_W(LHIST_W)) u_lht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (pred_lidx),
    .rd_hist_o  (pred_lhist),
    .upd_en_i   (upd_valid_i),
    .upd_idx_i  (upd_lidx),
    .upd_bit_i  (upd_taken_i),
    .upd_hist_o (upd_lhist)
  );

  bp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(LCTR_INIT)) u_lctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (pred_lhist),
    .rd_hi_o  (pred_loc_o),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_lhist),
    .wr_up_i  (upd_taken_i)
  );

  // chooser trains on disagreement, toward the component that was right
  assign ch_train = upd_valid_i && (upd_glob_pred_i != upd_loc_pred_i);
  assign ch_up    = (upd_glob_pred_i == upd_taken_i);

  bp_ctr_table #(.IDX_W(CHOOSE_IW), .CTR_W(CCTR_W), .INIT(CCTR_INIT)) u_chooser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (pred_cidx),
    .rd_hi_o  (pred_use_glob_o),
    .wr_en_i  (ch_train),
    .wr_idx_i (upd_cidx),
    .wr_up_i  (ch_up)
  );

  assign pred_taken_o = pred_use_glob_o ? pred_glob_o : pred_loc_o;

  a_r7_follows_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_glob_o != pred_loc_o) |-> (pred_taken_o == pred_glob_o) == pred_use_glob_o);
endmodule

// File: tb/tournament_bp_tb.sv
module tournament_bp_tb;
  localparam int GH_N = 4096;
  localparam int LH_N = 1024;
  localparam int CH_N = 4096;
  localparam int LC_N = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o, pred_glob_o, pred_loc_o, pred_use_glob_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic        upd_glob_pred_i = 1'b0;
  logic        upd_loc_pred_i = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  tournament_bp u_dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pred_pc_i       (pred_pc_i),
    .pred_taken_o    (pred_taken_o),
    .pred_glob_o     (pred_glob_o),
    .pred_loc_o      (pred_loc_o),
    .pred_use_glob_o (pred_use_glob_o),
    .upd_valid_i     (upd_valid_i),
    .upd_pc_i        (upd_pc_i),
    .upd_taken_i     (upd_taken_i),
    .upd_glob_pred_i (upd_glob_pred_i),
    .upd_loc_pred_i  (upd_loc_pred_i)
  );

  // reference state built from the requirements
  int m_g [GH_N];
  int m_l [LC_N];
  int m_c [CH_N];
  int m_h [LH_N];
  int m_ghr;

  function automatic void m_reset();
    for (int i = 0; i < GH_N; i++) m_g[i] = 1;
    for (int i = 0; i < CH_N; i++) m_c[i] = 1;
    for (int i = 0; i < LC_N; i++) m_l[i] = 3;
    for (int i = 0; i < LH_N; i++) m_h[i] = 0;
    m_ghr = 0;
  endfunction

  function automatic int sat(int v, int maxv, logic up);
    if (up) return (v < maxv) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  function automatic void m_predict(input logic [31:0] pc,
                                    output logic g, output logic l,
                                    output logic u, output logic t);
    int ci = int'(pc >> 2) % CH_N;
    int li = int'(pc >> 2) % LH_N;
    g = (m_g[m_ghr] >= 2);
    l = (m_l[m_h[li]] >= 4);
    u = (m_c[ci] >= 2);
    t = u ? g : l;
  endfunction

  function automatic void m_update(logic [31:0] pc, logic tk, logic gp, logic lp);
    int ci = int'(pc >> 2) % CH_N;
    int li = int'(pc >> 2) % LH_N;
    m_g[m_ghr] = sat(m_g[m_ghr], 3, tk);
    m_l[m_h[li]] = sat(m_l[m_h[li]], 7, tk);
    if (gp != lp) m_c[ci] = sat(m_c[ci], 3, gp == tk);
    m_h[li] = ((m_h[li] << 1) | int'(tk)) % LH_N;
    m_ghr = ((m_ghr << 1) | int'(tk)) % GH_N;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    upd_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    m_reset();
    rst_ni = 1'b1;
  endtask

  task automatic upd(logic [31:0] pc, logic tk, logic gp, logic lp, logic vld);
    @(negedge clk_i);
    upd_valid_i = vld;
    upd_pc_i = pc;
    upd_taken_i = tk;
    upd_glob_pred_i = gp;
    upd_loc_pred_i = lp;
    @(posedge clk_i);
    #1;
    upd_valid_i = 1'b0;
    if (vld) m_update(pc, tk, gp, lp);
  endtask

  task automatic look(logic [31:0] pc);
    @(negedge clk_i);
    pred_pc_i = pc;
    #1;
  endtask

  // compare all four outputs with the reference; return captured components
  task automatic chk_model(logic [31:0] pc, string req, output logic g, output logic l);
    logic u, t;
    look(pc);
    m_predict(pc, g, l, u, t);
    check(req, "glob", pred_glob_o, g);
    check(req, "loc", pred_loc_o, l);
    check(req, "use_glob", pred_use_glob_o, u);
    check(req, "taken", pred_taken_o, t);
  endtask

  // {pc selector[2:1], outcome[0]}
  localparam logic [2:0] VEC [16] = '{
    3'b001, 3'b001, 3'b001, 3'b000,
    3'b011, 3'b010, 3'b101, 3'b011,
    3'b001, 3'b001, 3'b001, 3'b000,
    3'b010, 3'b111, 3'b101, 3'b110
  };
  localparam logic [31:0] PCS [4] = '{32'h0000_0100, 32'h0000_1204,
                                      32'h0000_2f08, 32'h0000_410c};

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic g, l;
    logic [31:0] pq, pr, ps, pp;
    pq = 32'h0000_0100;
    pr = 32'h0000_0200;
    ps = 32'h0000_0300;
    pp = 32'h0000_0a40;

    // R1 reset state
    do_reset();
    look(32'h1234_5678);
    check("R1", "taken", pred_taken_o, 1'b0);
    check("R1", "glob", pred_glob_o, 1'b0);
    check("R1", "loc", pred_loc_o, 1'b0);
    check("R1", "use_glob", pred_use_glob_o, 1'b0);

    // R5: shared second-level table; R2 index by new history
    upd(pq, 1'b1, 1'b0, 1'b0, 1'b1);
    look(pr);
    check("R5", "loc via other branch history 0", pred_loc_o, 1'b1);
    look(pq);
    check("R6", "loc after history shift", pred_loc_o, 1'b0);
    check("R2", "glob at history 1", pred_glob_o, 1'b0);
    // R4: twelve not-taken shift history back to zero
    for (int i = 0; i < 12; i++) begin
      chk_model(ps, "R3", g, l);
      upd(ps, 1'b0, g, l, 1'b1);
    end
    look(pr);
    check("R4", "glob after history wrap", pred_glob_o, 1'b1);
    check("R7", "local selected", pred_use_glob_o, 1'b0);
    check("R7", "final follows local", pred_taken_o, 1'b0);
    check("R6", "local counter decremented", pred_loc_o, 1'b0);

    // R8 chooser training at pp
    do_reset();
    upd(pp, 1'b1, 1'b1, 1'b0, 1'b1);
    look(pp);
    check("R8", "global correct moves to global", pred_use_glob_o, 1'b1);
    check("R7", "final equals glob", pred_taken_o, pred_glob_o);
    upd(pp, 1'b0, 1'b1, 1'b1, 1'b1);
    look(pp);
    check("R8", "agreement leaves chooser", pred_use_glob_o, 1'b1);
    upd(pp, 1'b0, 1'b1, 1'b0, 1'b1);
    look(pp);
    check("R8", "local correct moves to local", pred_use_glob_o, 1'b0);
    for (int i = 0; i < 3; i++) upd(pp, 1'b1, 1'b0, 1'b1, 1'b1);
    upd(pp, 1'b1, 1'b1, 1'b0, 1'b1);
    look(pp);
    check("R8", "low saturation", pred_use_glob_o, 1'b0);
    upd(pp, 1'b1, 1'b1, 1'b0, 1'b1);
    look(pp);
    check("R8", "climb to global", pred_use_glob_o, 1'b1);
    // R9 invalid update is ignored
    upd(pp, 1'b1, 1'b0, 1'b1, 1'b0);
    chk_model(pp, "R9", g, l);
    check("R9", "chooser unchanged", pred_use_glob_o, 1'b1);
    for (int i = 0; i < 3; i++) upd(pp, 1'b0, 1'b0, 1'b1, 1'b1);
    upd(pp, 1'b1, 1'b0, 1'b1, 1'b1);
    look(pp);
    check("R8", "high saturation", pred_use_glob_o, 1'b1);
    chk_model(pp, "R8", g, l);

    // vector walk against reference: R2 R3 R4 R5 R6 R7 R8
    do_reset();
    for (int rep = 0; rep < 12; rep++) begin
      for (int i = 0; i < 16; i++) begin
        chk_model(PCS[VEC[i][2:1]], "R7", g, l);
        upd(PCS[VEC[i][2:1]], VEC[i][0], g, l, 1'b1);
      end
    end
    chk_model(PCS[0], "R6", g, l);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule